// File: doc/BRIEF.md
# Two-Thread Capped Scheduler Entry Allocator

This block fills one pooled scheduler array from two per-thread micro-op streams. Any free entry can go to either thread, so a thread may hold most of the array while the other thread has nothing to send. A per-thread occupancy cap, supplied on a plain input, stops either thread from taking every entry. Each cycle the block grants at most one micro-op. It grants only a thread that has a pending micro-op, is below its cap, and finds at least one free entry. When both threads qualify, they take turns.

The granted micro-op is written into the lowest free entry. The entry records which thread owns it. A release port frees an entry, usually on dispatch. Each release decrements the counter of the thread that owns that entry. The counters, the busy map and the owner map are brought out so that the surrounding scheduler can see them.

Each input stream uses valid/ready. A micro-op is accepted in the cycle where its valid and ready are both high. Ready may stay low for any number of cycles: when the array is full, when the thread sits at its cap, or when the other thread wins the turn. Ready never rises without the matching valid. The write port on the array side has no back-pressure.

Top module: `sa_thresh_alloc`

## Requirements
- R1: After reset every entry is free, both occupancy counters read 0, and the round-robin preference points to thread 0.
- R2: `in_ready[t]` is high only in a cycle where `in_valid[t]` is high, a free entry exists, and the counter of thread t is below its effective cap.
- R3: A thread's occupancy never rises above its effective cap. A thread at its cap gets no grant even while free entries remain.
- R4: When both threads qualify in the same cycle, the grant goes to the preferred thread. After any grant to thread t, the preferred thread becomes the other thread. Two tied threads therefore alternate.
- R5: When only one thread qualifies, it is granted in that cycle, whatever the preference.
- R6: A grant writes `alloc_idx` as the lowest-numbered free entry. In the next cycle that bit of `busy_vec` is 1 and the same bit of `owner_vec` holds the thread id (0 = thread 0, 1 = thread 1).
- R7: A release of a busy entry (`rel_valid` with `rel_idx` naming it) clears its `busy_vec` bit and decrements its owner's counter in the next cycle.
- R8: A release naming an entry that is not busy has no effect on any counter or map bit.
- R9: When one thread is granted and one of its own entries is released in the same cycle, that thread's counter is unchanged in the next cycle.
- R10: At every cycle each thread's counter equals the number of busy entries whose owner bit names that thread.
- R11: When all entries are busy, no grant is made.
- R12: At most one `in_ready` bit is high. `alloc_tid` names the granted thread, and `alloc_data` equals the payload of that thread.
- R13: The effective cap is the programmed cap, limited to ENTRIES. A cap of 0 blocks the thread entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Pending micro-op per thread (bit t = thread t) |
| in_ready | output | 2 | Acceptance per thread, one-hot or zero |
| in_data | input | 2*DATA_W | Payloads, thread t in bits [t*DATA_W +: DATA_W] |
| thr_lim | input | 2*CW | Occupancy cap per thread, thread t in bits [t*CW +: CW] |
| rel_valid | input | 1 | Release request |
| rel_idx | input | IW | Entry to release |
| alloc_valid | output | 1 | Array write strobe |
| alloc_tid | output | 1 | Owner thread of the written entry |
| alloc_idx | output | IW | Entry being written |
| alloc_data | output | DATA_W | Payload being written |
| occ | output | 2*CW | Occupancy counters, thread t in bits [t*CW +: CW] |
| busy_vec | output | ENTRIES | Busy flag per entry |
| owner_vec | output | ENTRIES | Owner thread id per entry |

## Verification
A grant and a release can land in the same cycle, either on the same thread or on different threads. When they hit the same thread, the counter must come out unchanged. The bench provokes this with a directed step that releases one of a thread's entries while that thread holds a pending micro-op below its cap. Random phases then overlap releases with grants, and some of those releases name idle entries. Each following cycle, the counters and the busy and owner maps are compared with a bench model that applies the release before the grant and never lets the two touch the same entry.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int NTHR = 2;
  typedef logic tid_t;
endpackage

// File: rtl/sa_occ_counter.sv
module sa_occ_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (inc && !dec) cnt_q <= cnt_q + CW'(1);
    else if (dec && !inc) cnt_q <= cnt_q - CW'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sa_free_track.sv
module sa_free_track import sa_pkg::*; #(
  parameter int ENTRIES = 8,
  parameter int IW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IW-1:0]      set_idx,
  input  tid_t               set_tid,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  output logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] owner,
  output logic               free_any,
  output logic [IW-1:0]      free_idx,
  output logic               clr_hit,
  output tid_t               clr_tid
);
  logic [ENTRIES-1:0] busy_q, owner_q;
  logic               clr_in_rng;

  // lowest free entry wins
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign clr_in_rng = int'(clr_idx) < ENTRIES;
  assign clr_hit    = clr_en && clr_in_rng && busy_q[clr_idx];
  assign clr_tid    = owner_q[clr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      owner_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (set_en && set_idx == IW'(e)) begin
          busy_q[e]  <= 1'b1;
          owner_q[e] <= set_tid;
        end else if (clr_hit && clr_idx == IW'(e)) begin
          busy_q[e] <= 1'b0;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign owner = owner_q;
endmodule

// File: rtl/sa_rr_arb.sv
module sa_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  logic pref_q;  // thread preferred on a tie

  always_comb begin
    if (req == 2'b11) gnt = pref_q ? 2'b10 : 2'b01;
    else              gnt = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pref_q <= 1'b0;
    else if (|gnt) pref_q <= gnt[0];
  end
endmodule

// File: rtl/sa_thresh_alloc.sv
module sa_thresh_alloc import sa_pkg::*; #(
  parameter  int ENTRIES = 8,
  parameter  int DATA_W  = 16,
  localparam int CW      = $clog2(ENTRIES + 1),
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTHR-1:0]        in_valid,
  output logic [NTHR-1:0]        in_ready,
  input  logic [NTHR*DATA_W-1:0] in_data,
  input  logic [NTHR*CW-1:0]     thr_lim,
  input  logic                   rel_valid,
  input  logic [IW-1:0]          rel_idx,
  output logic                   alloc_valid,
  output logic                   alloc_tid,
  output logic [IW-1:0]          alloc_idx,
  output logic [DATA_W-1:0]      alloc_data,
  output logic [NTHR*CW-1:0]     occ,
  output logic [ENTRIES-1:0]     busy_vec,
  output logic [ENTRIES-1:0]     owner_vec
);
  logic            free_any;
  logic [IW-1:0]   free_idx;
  logic            clr_hit;
  tid_t            clr_tid;
  logic [NTHR-1:0] elig, gnt;

  sa_free_track #(.ENTRIES(ENTRIES), .IW(IW)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (alloc_valid),
    .set_idx  (free_idx),
    .set_tid  (alloc_tid),
    .clr_en   (rel_valid),
    .clr_idx  (rel_idx),
    .busy     (busy_vec),
    .owner    (owner_vec),
    .free_any (free_any),
    .free_idx (free_idx),
    .clr_hit  (clr_hit),
    .clr_tid  (clr_tid)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CW-1:0] cap, cnt;
    assign cap = (thr_lim[t*CW +: CW] > CW'(ENTRIES)) ? CW'(ENTRIES) : thr_lim[t*CW +: CW];
    assign elig[t] = in_valid[t] && free_any && (cnt < cap);

    sa_occ_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (gnt[t]),
      .dec   (clr_hit && (clr_tid == tid_t'(t))),
      .cnt   (cnt)
    );
    assign occ[t*CW +: CW] = cnt;
  end

  sa_rr_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .gnt   (gnt)
  );

  assign in_ready    = gnt;
  assign alloc_valid = |gnt;
  assign alloc_tid   = gnt[1];
  assign alloc_idx   = free_idx;
  assign alloc_data  = gnt[1] ? in_data[DATA_W +: DATA_W] : in_data[0 +: DATA_W];
endmodule

// File: rtl/sa_thresh_alloc_chk.sv
module sa_thresh_alloc_chk #(
  parameter  int ENTRIES = 8,
  parameter  int DATA_W  = 16,
  localparam int CW      = $clog2(ENTRIES + 1),
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           in_valid,
  input logic [1:0]           in_ready,
  input logic [2*CW-1:0]      thr_lim,
  input logic                 rel_valid,
  input logic [IW-1:0]        rel_idx,
  input logic                 alloc_valid,
  input logic                 alloc_tid,
  input logic [IW-1:0]        alloc_idx,
  input logic [2*CW-1:0]      occ,
  input logic [ENTRIES-1:0]   busy_vec,
  input logic [ENTRIES-1:0]   owner_vec
);
  logic [CW-1:0] o0, o1, c0, c1;
  assign o0 = occ[0 +: CW];
  assign o1 = occ[CW +: CW];
  assign c0 = (thr_lim[0 +: CW] > CW'(ENTRIES)) ? CW'(ENTRIES) : thr_lim[0 +: CW];
  assign c1 = (thr_lim[CW +: CW] > CW'(ENTRIES)) ? CW'(ENTRIES) : thr_lim[CW +: CW];

  p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == 2'b00);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o0 > $past(o0)) |-> ($past(o0) < $past(c0)));
  p_no_overflow_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o1 > $past(o1)) |-> ($past(o1) < $past(c1)));
  p_alloc_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> (busy_vec[$past(alloc_idx)] && owner_vec[$past(alloc_idx)] == $past(alloc_tid)));
  p_alloc_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> !busy_vec[alloc_idx]);
  p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && busy_vec[rel_idx] && !alloc_valid) |=> !busy_vec[$past(rel_idx)]);
  p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && rel_valid && busy_vec[rel_idx] && owner_vec[rel_idx] == alloc_tid) |=> $stable(occ));
  p_count_t0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_vec & ~owner_vec) == int'(o0));
  p_count_t1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_vec & owner_vec) == int'(o1));
  p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> (in_ready == 2'b00));
  p_one_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
endmodule

bind sa_thresh_alloc sa_thresh_alloc_chk #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .thr_lim     (thr_lim),
  .rel_valid   (rel_valid),
  .rel_idx     (rel_idx),
  .alloc_valid (alloc_valid),
  .alloc_tid   (alloc_tid),
  .alloc_idx   (alloc_idx),
  .occ         (occ),
  .busy_vec    (busy_vec),
  .owner_vec   (owner_vec)
);

// File: tb/tb_sa_thresh_alloc.sv
`timescale 1ns/1ps
module tb_sa_thresh_alloc;
  localparam int ENTRIES = 8;
  localparam int DATA_W  = 16;
  localparam int CW      = 4;
  localparam int IW      = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           in_valid, in_ready;
  logic [2*DATA_W-1:0]  in_data;
  logic [2*CW-1:0]      thr_lim;
  logic                 rel_valid;
  logic [IW-1:0]        rel_idx;
  logic                 alloc_valid, alloc_tid;
  logic [IW-1:0]        alloc_idx;
  logic [DATA_W-1:0]    alloc_data;
  logic [2*CW-1:0]      occ;
  logic [ENTRIES-1:0]   busy_vec, owner_vec;

  always #10 clk = ~clk;

  sa_thresh_alloc #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .thr_lim(thr_lim), .rel_valid(rel_valid), .rel_idx(rel_idx),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_idx(alloc_idx),
    .alloc_data(alloc_data), .occ(occ), .busy_vec(busy_vec), .owner_vec(owner_vec));

  int n_chk = 0, n_fail = 0;
  bit m_busy[ENTRIES];
  bit m_own[ENTRIES];
  int m_occ[2];
  int m_pref;
  int thr[2];
  string st_tag = "R10";

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v > ENTRIES) ? ENTRIES : v;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < ENTRIES; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic logic [ENTRIES-1:0] mvec(bit own_sel);
    logic [ENTRIES-1:0] v;
    for (int i = 0; i < ENTRIES; i++) v[i] = own_sel ? (m_busy[i] && m_own[i]) : m_busy[i];
    return v;
  endfunction

  task automatic check_state();
    chk(occ[0 +: CW] == m_occ[0], st_tag, occ[0 +: CW], m_occ[0]);
    chk(occ[CW +: CW] == m_occ[1], st_tag, occ[CW +: CW], m_occ[1]);
    chk(busy_vec == mvec(1'b0), "R6", busy_vec, mvec(1'b0));
    chk((busy_vec & owner_vec) == mvec(1'b1), "R6", busy_vec & owner_vec, mvec(1'b1));
    chk($countones(busy_vec & ~owner_vec) == occ[0 +: CW], "R10",
        $countones(busy_vec & ~owner_vec), occ[0 +: CW]);
    chk(occ[0 +: CW] <= eff(thr[0]), "R3", occ[0 +: CW], eff(thr[0]));
    chk(occ[CW +: CW] <= eff(thr[1]), "R3", occ[CW +: CW], eff(thr[1]));
  endtask

  task automatic step(bit v0, bit v1, bit rv, int ri);
    int lf, g;
    bit e0, e1, rhit;
    logic [DATA_W-1:0] d0, d1;
    logic [1:0] exp_rdy;
    string tag;
    @(negedge clk);
    check_state();
    d0 = DATA_W'($urandom);
    d1 = DATA_W'($urandom);
    in_valid  = {v1, v0};
    in_data   = {d1, d0};
    rel_valid = rv;
    rel_idx   = IW'(ri);
    #2;
    lf = lowest_free();
    e0 = v0 && lf >= 0 && m_occ[0] < eff(thr[0]);
    e1 = v1 && lf >= 0 && m_occ[1] < eff(thr[1]);
    g = -1;
    if (e0 && e1)  g = m_pref;
    else if (e0)   g = 0;
    else if (e1)   g = 1;
    exp_rdy = (g < 0) ? 2'b00 : (g == 0 ? 2'b01 : 2'b10);
    if (e0 && e1)                  tag = "R4";
    else if (g >= 0)               tag = "R5";
    else if ((v0 || v1) && lf < 0) tag = "R11";
    else if ((v0 && (thr[0] == 0 || thr[0] > ENTRIES)) || (v1 && (thr[1] == 0 || thr[1] > ENTRIES)))
                                   tag = "R13";
    else if (v0 || v1)             tag = "R3";
    else                           tag = "R2";
    chk(in_ready == exp_rdy, tag, in_ready, exp_rdy);
    chk(alloc_valid == (g >= 0), "R12", alloc_valid, g >= 0);
    if (g >= 0) begin
      chk(alloc_idx == lf, "R6", alloc_idx, lf);
      chk(alloc_tid == g, "R12", alloc_tid, g);
      chk(alloc_data == (g == 1 ? d1 : d0), "R12", alloc_data, g == 1 ? d1 : d0);
    end
    // model: release on pre-grant state, then grant
    rhit = rv && ri < ENTRIES && m_busy[ri];
    st_tag = "R10";
    if (rv && !rhit) st_tag = "R8";
    if (rhit) begin
      st_tag = "R7";
      if (g >= 0 && m_own[ri] == g) st_tag = "R9";
      m_busy[ri] = 1'b0;
      m_occ[m_own[ri]]--;
    end
    if (g >= 0) begin
      m_busy[lf] = 1'b1;
      m_own[lf]  = g[0];
      m_occ[g]++;
      m_pref = (g == 0) ? 1 : 0;
    end
  endtask

  task automatic set_thr(int a, int b);
    thr[0] = a; thr[1] = b;
    thr_lim = {CW'(b), CW'(a)};
  endtask

  task automatic drain();
    for (int i = 0; i < ENTRIES; i++) step(0, 0, 1, i);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = '0; in_data = '0; rel_valid = 1'b0; rel_idx = '0;
    set_thr(6, 6);
    for (int i = 0; i < ENTRIES; i++) begin m_busy[i] = 0; m_own[i] = 0; end
    m_occ[0] = 0; m_occ[1] = 0; m_pref = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(busy_vec == '0, "R1", busy_vec, 0);
    chk(occ == '0, "R1", occ, 0);
    // busy thread 0 climbs to its cap, idle thread 1
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0);
    // idle thread 1 gets work: granted at once, then array fills
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
    drain();
    // same-cycle grant and release on thread 0 (R9)
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    // release of an idle entry (R8)
    step(0, 0, 1, 7);
    step(0, 0, 0, 0);
    drain();
    // tie: alternation (R4)
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0);
    drain();
    // cap above array size and cap of zero (R13)
    set_thr(15, 0);
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0);
    drain();
    // random phases
    for (int r = 0; r < 4; r++) begin
      set_thr(1 + int'($urandom_range(0, 8)), 1 + int'($urandom_range(0, 8)));
      for (int i = 0; i < 400; i++)
        step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 5,
             $urandom_range(0, 9) < 4, int'($urandom_range(0, ENTRIES - 1)));
      drain();
    end
    @(negedge clk);
    check_state();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule